// File: doc/BRIEF.md
# Chromatic Encoder Step Selector

This block turns a debounced two-pin rotary encoder into a chromatic pitch position and a matching playback rate. Each detent moves a step index by one semitone within a range of 25 positions, which spans one octave below unity to one octave above. The index drives a built-in table of equal-tempered ratios, and the block outputs the result as an unsigned 8.8 fixed-point speed word, where 0x0100 means normal speed.

The encoder is not watched on every clock. A sample tick, typically the audio sample strobe, is divided down, and the pins are looked at only once per decimation period. That slow sampling is the only filtering applied. A playback engine reads the speed word and adds it to its fractional read pointer once per sample.

Top module: `chroma_step_sel`

## Requirements
- R1: The encoder pins are sampled only on every DECIM-th pulse of `tick` since reset (ticks DECIM, 2·DECIM, …). Pin activity that begins and ends between two such samples has no effect.
- R2: A detent is recognised when `enc_a` is seen low at a sample after being seen high at the previous one, or at the first sample after reset. While `enc_a` stays low across further samples, nothing more happens. It must be seen high again before the next detent counts.
- R3: At a recognised detent, `enc_b` low raises the step index by one, and `enc_b` high lowers it by one.
- R4: The step index never leaves 0..24. A raise at 24 leaves it at 24, and a lower at 0 leaves it at 0.
- R5: The speed word equals round(256 · 2^((step_idx − 12)/12)). For example, index 0 gives 0x0080, 7 gives 0x00C0, 12 gives 0x0100, 17 gives 0x0156, 23 gives 0x01E3 and 24 gives 0x0200.
- R6: The speed word changes only in the same cycle as the step index. A detent that saturates leaves both unchanged.
- R7: After reset the step index is 12 and the speed word is 0x0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample strobe |
| enc_a | input | 1 | Encoder detent pin; a falling edge marks a detent |
| enc_b | input | 1 | Encoder direction pin |
| step_idx | output | 5 | Chromatic step, 0..24, where 12 is unity |
| speed | output | 16 | Playback rate in unsigned 8.8 format |

## Verification
The bench builds the block with DECIM set to 4 instead of 64. This makes each sampling window a few ticks long, so a run can walk the index across all 25 table entries, hold it against both stops, and keep `enc_a` low for several windows in a row. Because the window is short, the bench can also keep count of tick phase. That lets it place a brief low pulse on `enc_a` entirely between two samples and show that the pulse is missed.

// File: rtl/chroma_step_sel.sv
module chroma_step_sel #(
  parameter int DECIM = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        enc_a,
  input  logic        enc_b,
  output logic [4:0]  step_idx,
  output logic [15:0] speed
);
  localparam int CW = $clog2(DECIM + 1);
  localparam logic [4:0]  TOP  = 5'd24;
  localparam logic [4:0]  MID  = 5'd12;
  localparam logic [15:0] UNIT = 16'h0100;

  logic [CW-1:0] cnt;
  logic          seen;
  logic          sample;
  logic          detent;
  logic [4:0]    nxt;

  function automatic logic [15:0] rate(input logic [4:0] i);
    case (i)
      5'd0:  rate = 16'h0080;
      5'd1:  rate = 16'h0088;
      5'd2:  rate = 16'h0090;
      5'd3:  rate = 16'h0098;
      5'd4:  rate = 16'h00A1;
      5'd5:  rate = 16'h00AB;
      5'd6:  rate = 16'h00B5;
      5'd7:  rate = 16'h00C0;
      5'd8:  rate = 16'h00CB;
      5'd9:  rate = 16'h00D7;
      5'd10: rate = 16'h00E4;
      5'd11: rate = 16'h00F2;
      5'd12: rate = 16'h0100;
      5'd13: rate = 16'h010F;
      5'd14: rate = 16'h011F;
      5'd15: rate = 16'h0130;
      5'd16: rate = 16'h0143;
      5'd17: rate = 16'h0156;
      5'd18: rate = 16'h016A;
      5'd19: rate = 16'h0180;
      5'd20: rate = 16'h0196;
      5'd21: rate = 16'h01AF;
      5'd22: rate = 16'h01C8;
      5'd23: rate = 16'h01E3;
      default: rate = 16'h0200;
    endcase
  endfunction

  assign sample = tick && (cnt == CW'(1));
  assign detent = sample && !enc_a && !seen;

  always_comb begin
    nxt = step_idx;
    if (detent) begin
      if (!enc_b) nxt = (step_idx >= TOP) ? TOP : step_idx + 5'd1;
      else if (step_idx != 5'd0) nxt = step_idx - 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= CW'(DECIM);
      seen     <= 1'b0;
      step_idx <= MID;
      speed    <= UNIT;
    end else begin
      if (tick) cnt <= sample ? CW'(DECIM) : cnt - CW'(1);
      if (sample) seen <= !enc_a;
      step_idx <= nxt;
      if (nxt != step_idx) speed <= rate(nxt);
    end
  end
endmodule

module chroma_step_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [4:0]  step_idx,
  input logic [15:0] speed
);
  assert_reset_unity_R7: assert property (@(posedge clk)
    $rose(rst_n) |-> (step_idx == 5'd12 && speed == 16'h0100));

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= 5'd24);

  assert_speed_follows_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed) |-> !$stable(step_idx));

  assert_move_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_idx) |-> $past(tick));

  assert_rate_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_idx) < step_idx) |-> (speed > $past(speed)));
endmodule

bind chroma_step_sel chroma_step_sel_chk u_chk (.*);

// File: tb/test_chroma_step_sel.sv
module test_chroma_step_sel;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic enc_a = 1'b1;
  logic enc_b = 1'b0;
  logic [4:0]  step_idx;
  logic [15:0] speed;

  chroma_step_sel #(.DECIM(D)) i_chroma_step_sel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enc_a(enc_a), .enc_b(enc_b),
    .step_idx(step_idx), .speed(speed)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    idx;
    int    spd;
    string req;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;
  int tc = 0;
  int model = 12;
  bit go = 1'b0;
  bit done = 1'b0;

  function automatic int exp_rate(input int i);
    real r;
    r = 256.0 * (2.0 ** ((i - 12) / 12.0));
    return $rtoi(r + 0.5);
  endfunction

  always @(negedge clk) begin
    if (go && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (int'(step_idx) != e.idx || int'(speed) != e.spd) begin
        errors++;
        $display("FAIL %s: idx=%0d speed=%h expected idx=%0d speed=%h",
                 e.req, step_idx, speed, e.idx, e.spd[15:0]);
      end
      go = 1'b0;
    end
  end

  task automatic expect_now(input string req);
    item_t e;
    e.idx = model;
    e.spd = exp_rate(model);
    e.req = req;
    q.push_back(e);
    go = 1'b1;
    wait (go == 1'b0);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    tc++;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) do_tick();
  endtask

  task automatic align();
    while (tc % D != 0) do_tick();
  endtask

  task automatic detent(input bit cw, input string req);
    @(negedge clk);
    enc_b = ~cw;
    enc_a = 1'b0;
    ticks(D);
    if (cw) model = (model >= 24) ? 24 : model + 1;
    else    model = (model <= 0) ? 0 : model - 1;
    expect_now(req);
    enc_a = 1'b1;
    ticks(D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R7 reset state");

    align();
    enc_b = 1'b0;
    enc_a = 1'b0;
    ticks(D - 1);
    enc_a = 1'b1;
    ticks(1);
    expect_now("R1 pulse between samples ignored");

    detent(1'b0, "R3 enc_b high lowers");
    detent(1'b1, "R3 enc_b low raises");

    @(negedge clk);
    enc_b = 1'b0;
    enc_a = 1'b0;
    ticks(5 * D);
    model = model + 1;
    expect_now("R2 held low counts once");
    enc_b = 1'b1;
    ticks(2 * D);
    expect_now("R2 enc_b change while held low ignored");
    enc_a = 1'b1;
    ticks(D);

    for (int i = 0; i < 13; i++) detent(1'b1, "R5 table walk up");
    detent(1'b1, "R4 saturate at 24");
    detent(1'b1, "R6 no speed change at top");
    for (int i = 0; i < 24; i++) detent(1'b0, "R5 table walk down");
    detent(1'b0, "R4 saturate at 0");
    detent(1'b0, "R6 no speed change at bottom");
    for (int i = 0; i < 7; i++) detent(1'b1, "R5 index 7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule